// File: doc/BRIEF.md
# Signal Cache with Bus Bypass

This block sits beside an acceleration core and holds a small set of shared signal values. The core's datapath issues signal reads and writes tagged with a signal ID. When the ID has been configured into one of the cache entries, the access is served locally: a read returns data in the same cycle and a write lands on the next clock edge. Neither kind stalls.

Each local write is also forwarded over a point-to-point link to the neighbouring engine. Writes arriving from the neighbour update the matching entries. Two adjacent engines can therefore exchange bypassed signals without touching shared bus memory.

Any ID that is not configured is sent to the shared system bus through a request/acknowledge master port, and the datapath is stalled until the acknowledge arrives. Configuration writes that arrive while a bus access is outstanding are held back and applied once the access has finished.

Top module: `sig_cache`

## Requirements
- R1: After reset every entry is invalid, and `dp_ready_o`, `bus_req_o` and `nb_we_o` are low. An access to any ID after reset therefore goes to the bus.
- R2: A datapath read with no bus access outstanding, whose ID matches a valid entry, raises `dp_ready_o` in the same cycle with `dp_rdata_o` equal to the entry value. It never raises `bus_req_o`.
- R3: A datapath write that hits updates every matching entry, and the new value is readable from the next cycle. In the same cycle it drives `nb_we_o`=1, `nb_id_o`=ID and `nb_wdata_o`=data. It never raises `bus_req_o`.
- R4: A neighbour write (`nb_we_i`) updates every valid entry whose ID equals `nb_id_i`. A datapath read of that entry in the same cycle returns the old value, and a read in the next cycle returns the new value.
- R5: An access whose ID misses raises `bus_req_o` on the next cycle, with `bus_we_o`, `bus_addr_o` (the ID zero-extended) and `bus_wdata_o` taken from the access. `dp_ready_o` stays low until `bus_ack_i`. In the acknowledge cycle `dp_ready_o` is 1 and `dp_rdata_o` equals `bus_rdata_i`. `bus_req_o` is low in the following cycle, so each access makes exactly one bus transaction.
- R6: While `bus_req_o` waits for an acknowledge, `bus_addr_o`, `bus_we_o` and `bus_wdata_o` stay stable.
- R7: With no bus access outstanding, a configuration write (`cfg_we_i`, entry `cfg_idx_i`, valid `cfg_valid_i`, ID `cfg_id_i`) takes effect on the next cycle and clears the entry value to zero. If `cfg_valid_i`=0, the entry is removed and its ID goes to the bus again.
- R8: A configuration write issued while a bus access is outstanding, including in its acknowledge cycle, is held. It is applied at the end of the first cycle after the access completes. An access starting in that cycle still uses the old table. If several such writes arrive, the last one is kept.
- R9: A neighbour write to an ID held by no valid entry changes no entry value.
- R10: If a datapath hit write and a neighbour write target the same entry in the same cycle, the datapath value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dp_req_i | input | 1 | Datapath access request, held until ready |
| dp_we_i | input | 1 | Datapath access is a write |
| dp_id_i | input | ID_W | Signal ID of the access |
| dp_wdata_i | input | DATA_W | Write data |
| dp_ready_o | output | 1 | Access completes this cycle |
| dp_rdata_o | output | DATA_W | Read data, valid with ready |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Entry index to configure |
| cfg_valid_i | input | 1 | Entry enabled for bypass |
| cfg_id_i | input | ID_W | Signal ID bound to the entry |
| nb_we_i | input | 1 | Write strobe from neighbour engine |
| nb_id_i | input | ID_W | Neighbour write signal ID |
| nb_wdata_i | input | DATA_W | Neighbour write data |
| nb_we_o | output | 1 | Write strobe to neighbour engine |
| nb_id_o | output | ID_W | Signal ID sent to neighbour |
| nb_wdata_o | output | DATA_W | Data sent to neighbour |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | Bus write |
| bus_addr_o | output | ADDR_W | Bus address (signal ID) |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_rdata_i | input | DATA_W | Bus read data |
| bus_ack_i | input | 1 | Bus acknowledge |

## Verification
The bench builds the block with its defaults: 8 entries, 8-bit IDs, 32-bit data and a 16-bit bus address. With these values it can bind all eight entries and sweep 48 IDs, both hitting and missing, in both directions. The bus acknowledge delay varies from zero to two cycles with the ID, so the same-cycle acknowledge and the stalled waits are both covered. The small table also makes it practical to check removal, neighbour collisions and configuration deferral, with the expected value of every entry computed in the bench.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic {
    BUS_IDLE = 1'b0,
    BUS_WAIT = 1'b1
  } bus_state_e;
endpackage

// File: rtl/sc_cfg_defer.sv
module sc_cfg_defer #(
  parameter int ID_W  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic             cfg_valid_i,
  input  logic [ID_W-1:0]  cfg_id_i,
  output logic             apply_o,
  output logic [IDX_W-1:0] apply_idx_o,
  output logic             apply_valid_o,
  output logic [ID_W-1:0]  apply_id_o
);
  logic             pend_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic             pend_valid_q;
  logic [ID_W-1:0]  pend_id_q;
  logic             hold;

  // a held write goes first; a new one arriving alongside it is held in turn
  assign hold = cfg_we_i && (busy_i || pend_q);

  always_comb begin
    apply_o       = 1'b0;
    apply_idx_o   = cfg_idx_i;
    apply_valid_o = cfg_valid_i;
    apply_id_o    = cfg_id_i;
    if (!busy_i && pend_q) begin
      apply_o       = 1'b1;
      apply_idx_o   = pend_idx_q;
      apply_valid_o = pend_valid_q;
      apply_id_o    = pend_id_q;
    end else if (!busy_i && cfg_we_i) begin
      apply_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b0;
      pend_idx_q   <= '0;
      pend_valid_q <= 1'b0;
      pend_id_q    <= '0;
    end else if (hold) begin
      pend_q       <= 1'b1;
      pend_idx_q   <= cfg_idx_i;
      pend_valid_q <= cfg_valid_i;
      pend_id_q    <= cfg_id_i;
    end else if (!busy_i && pend_q) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_entry_table.sv
module sc_entry_table #(
  parameter int N_ENT  = 8,
  parameter int ID_W   = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_apply_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_valid_i,
  input  logic [ID_W-1:0]   cfg_id_i,
  input  logic [ID_W-1:0]   lk_id_i,
  input  logic              loc_we_i,
  input  logic [DATA_W-1:0] loc_wdata_i,
  input  logic              nb_we_i,
  input  logic [ID_W-1:0]   nb_id_i,
  input  logic [DATA_W-1:0] nb_wdata_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [N_ENT-1:0]  hit_vec;
  logic [DATA_W-1:0] val_q [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic            vld_q;
    logic [ID_W-1:0] id_q;
    logic            cfg_sel;
    logic            nb_hit;

    assign cfg_sel    = cfg_apply_i && (cfg_idx_i == IDX_W'(g));
    assign hit_vec[g] = vld_q && (id_q == lk_id_i);
    assign nb_hit     = nb_we_i && vld_q && (id_q == nb_id_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q    <= 1'b0;
        id_q     <= '0;
        val_q[g] <= '0;
      end else if (cfg_sel) begin
        vld_q    <= cfg_valid_i;
        id_q     <= cfg_id_i;
        val_q[g] <= '0;
      end else if (loc_we_i && hit_vec[g]) begin
        val_q[g] <= loc_wdata_i;  // local side wins a collision
      end else if (nb_hit) begin
        val_q[g] <= nb_wdata_i;
      end
    end
  end

  assign hit_o = |hit_vec;

  always_comb begin
    rdata_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) rdata_o = val_q[i];
    end
  end
endmodule

// File: rtl/sc_bus_master.sv
module sc_bus_master #(
  parameter int ID_W   = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              bus_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o
);
  import sc_pkg::*;

  bus_state_e        st_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= BUS_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (st_q)
        BUS_IDLE: if (start_i) begin
          st_q    <= BUS_WAIT;
          we_q    <= we_i;
          addr_q  <= ADDR_W'(id_i);
          wdata_q <= wdata_i;
        end
        BUS_WAIT: if (bus_ack_i) st_q <= BUS_IDLE;
        default: st_q <= BUS_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q == BUS_WAIT);
  assign done_o      = busy_o && bus_ack_i;
  assign bus_req_o   = busy_o;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
endmodule

// File: rtl/sig_cache.sv
module sig_cache #(
  parameter int N_ENT  = 8,
  parameter int ID_W   = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dp_req_i,
  input  logic              dp_we_i,
  input  logic [ID_W-1:0]   dp_id_i,
  input  logic [DATA_W-1:0] dp_wdata_i,
  output logic              dp_ready_o,
  output logic [DATA_W-1:0] dp_rdata_o,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_valid_i,
  input  logic [ID_W-1:0]   cfg_id_i,
  input  logic              nb_we_i,
  input  logic [ID_W-1:0]   nb_id_i,
  input  logic [DATA_W-1:0] nb_wdata_i,
  output logic              nb_we_o,
  output logic [ID_W-1:0]   nb_id_o,
  output logic [DATA_W-1:0] nb_wdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ack_i
);
  logic              busy, done, hit, byp, miss_start, loc_we;
  logic              ap_en, ap_valid;
  logic [IDX_W-1:0]  ap_idx;
  logic [ID_W-1:0]   ap_id;
  logic [DATA_W-1:0] tbl_rdata;

  assign byp        = dp_req_i && !busy && hit;
  assign miss_start = dp_req_i && !busy && !hit;
  assign loc_we     = byp && dp_we_i;

  sc_cfg_defer #(.ID_W(ID_W), .IDX_W(IDX_W)) u_defer (
    .clk_i, .rst_ni,
    .busy_i       (busy),
    .cfg_we_i, .cfg_idx_i, .cfg_valid_i, .cfg_id_i,
    .apply_o      (ap_en),
    .apply_idx_o  (ap_idx),
    .apply_valid_o(ap_valid),
    .apply_id_o   (ap_id)
  );

  sc_entry_table #(.N_ENT(N_ENT), .ID_W(ID_W), .DATA_W(DATA_W)) u_tbl (
    .clk_i, .rst_ni,
    .cfg_apply_i(ap_en),
    .cfg_idx_i  (ap_idx),
    .cfg_valid_i(ap_valid),
    .cfg_id_i   (ap_id),
    .lk_id_i    (dp_id_i),
    .loc_we_i   (loc_we),
    .loc_wdata_i(dp_wdata_i),
    .nb_we_i, .nb_id_i, .nb_wdata_i,
    .hit_o      (hit),
    .rdata_o    (tbl_rdata)
  );

  sc_bus_master #(.ID_W(ID_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
    .clk_i, .rst_ni,
    .start_i    (miss_start),
    .we_i       (dp_we_i),
    .id_i       (dp_id_i),
    .wdata_i    (dp_wdata_i),
    .bus_ack_i,
    .busy_o     (busy),
    .done_o     (done),
    .bus_req_o, .bus_we_o, .bus_addr_o, .bus_wdata_o
  );

  assign dp_ready_o = byp || done;
  assign dp_rdata_o = busy ? bus_rdata_i : tbl_rdata;
  assign nb_we_o    = loc_we;
  assign nb_id_o    = dp_id_i;
  assign nb_wdata_o = dp_wdata_i;
endmodule

// File: rtl/sig_cache_chk.sv
module sig_cache_chk #(
  parameter int ID_W   = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dp_ready_o,
  input logic              nb_we_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_ack_i
);
  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o);
  // R5
  one_txn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i |=> !bus_req_o);
  // R5
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |-> !dp_ready_o);
  // R6
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o));
  // R3
  nb_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nb_we_o |-> dp_ready_o && !bus_req_o);
endmodule

bind sig_cache sig_cache_chk #(.ID_W(ID_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .dp_ready_o, .nb_we_o, .bus_req_o, .bus_we_o,
  .bus_addr_o, .bus_wdata_o, .bus_ack_i
);

// File: tb/sig_cache_tb.sv
module sig_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_ENT  = 8;
  localparam int ID_W   = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dp_req = 0, dp_we = 0, dp_ready;
  logic [ID_W-1:0] dp_id = '0;
  logic [DATA_W-1:0] dp_wdata = '0, dp_rdata;
  logic cfg_we = 0, cfg_valid = 0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [ID_W-1:0] cfg_id = '0;
  logic nb_we_i = 0, nb_we_o;
  logic [ID_W-1:0] nb_id_i = '0, nb_id_o;
  logic [DATA_W-1:0] nb_wdata_i = '0, nb_wdata_o;
  logic bus_req, bus_we, bus_ack = 0;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata = '0;

  int n_chk = 0, n_err = 0;
  bit         m_vld [N_ENT];
  int         m_id  [N_ENT];
  logic [31:0] m_val [N_ENT];
  bit inj = 0;
  int inj_idx, inj_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_cache #(.N_ENT(N_ENT), .ID_W(ID_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .dp_req_i(dp_req), .dp_we_i(dp_we), .dp_id_i(dp_id), .dp_wdata_i(dp_wdata),
    .dp_ready_o(dp_ready), .dp_rdata_o(dp_rdata),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_valid_i(cfg_valid), .cfg_id_i(cfg_id),
    .nb_we_i(nb_we_i), .nb_id_i(nb_id_i), .nb_wdata_i(nb_wdata_i),
    .nb_we_o(nb_we_o), .nb_id_o(nb_id_o), .nb_wdata_o(nb_wdata_o),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int find(input int id);
    for (int i = 0; i < N_ENT; i++) if (m_vld[i] && m_id[i] == id) return i;
    return -1;
  endfunction

  function automatic logic [31:0] bus_val(input int id);
    return 32'hB500_0000 | (id * 32'h101);
  endfunction

  // entered just after a falling edge; returns just after a falling edge
  task automatic access(input bit we, input int id, input logic [31:0] wd, input string req);
    int k;
    int d;
    k = find(id);
    dp_req = 1; dp_we = we; dp_id = ID_W'(id); dp_wdata = wd;
    #1;
    if (k >= 0) begin
      chk(dp_ready, 1, {req, " hit ready"});
      if (!we) chk(dp_rdata, m_val[k], {req, " hit rdata"});
      chk(nb_we_o, we, {req, " R3 nb_we_o"});
      if (we) begin
        chk(nb_id_o, id, "R3 nb_id_o");
        chk(nb_wdata_o, wd, "R3 nb_wdata_o");
      end
      @(posedge clk); @(negedge clk);
      dp_req = 0;
      chk(bus_req, 0, {req, " hit no bus"});
      if (we) for (int i = 0; i < N_ENT; i++) if (m_vld[i] && m_id[i] == id) m_val[i] = wd;
    end else begin
      chk(dp_ready, 0, {req, " R5 miss stall"});
      chk(nb_we_o, 0, {req, " R5 miss no fwd"});
      @(posedge clk); @(negedge clk);
      if (inj) begin
        cfg_we = 1; cfg_idx = IDX_W'(inj_idx); cfg_valid = 1; cfg_id = ID_W'(inj_id);
      end
      chk(bus_req, 1, "R5 bus_req");
      chk(bus_we, we, "R5 bus_we");
      chk(bus_addr, id, "R5 bus_addr");
      if (we) chk(bus_wdata, wd, "R5 bus_wdata");
      d = id % 3;
      for (int c = 0; c < d; c++) begin
        #1 chk(dp_ready, 0, "R5 wait stall");
        @(posedge clk); @(negedge clk);
        cfg_we = 0;
        chk(bus_addr, id, "R6 addr stable");
      end
      bus_ack = 1; bus_rdata = bus_val(id);
      #1;
      chk(dp_ready, 1, "R5 ack ready");
      if (!we) chk(dp_rdata, bus_val(id), "R5 ack rdata");
      @(posedge clk); @(negedge clk);
      bus_ack = 0; dp_req = 0; cfg_we = 0;
      chk(bus_req, 0, "R5 single txn");
    end
  endtask

  task automatic cfg(input int idx, input bit v, input int id);
    cfg_we = 1; cfg_idx = IDX_W'(idx); cfg_valid = v; cfg_id = ID_W'(id);
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
    m_vld[idx] = v; m_id[idx] = id; m_val[idx] = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < N_ENT; i++) begin m_vld[i] = 0; m_id[i] = 0; m_val[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(dp_ready, 0, "R1 ready");
    chk(bus_req, 0, "R1 bus_req");
    chk(nb_we_o, 0, "R1 nb_we_o");
    access(0, 16, 0, "R1");

    // R7 bind all entries
    for (int i = 0; i < N_ENT; i++) cfg(i, 1, 16 + 3 * i);
    for (int i = 0; i < N_ENT; i++) access(0, 16 + 3 * i, 0, "R7 fresh zero");

    // R3/R5 write sweep, then R2/R5 read sweep
    for (int id = 0; id < 48; id++) access(1, id, 32'hA0000000 + id * 7, "R3/R5 write");
    for (int id = 0; id < 48; id++) access(0, id, 0, "R2/R5 read");

    // R4 neighbour write, same-cycle read sees old value
    nb_we_i = 1; nb_id_i = 8'd19; nb_wdata_i = 32'h1234_5678;
    dp_req = 1; dp_we = 0; dp_id = 8'd19;
    #1 chk(dp_rdata, m_val[1], "R4 old value");
    @(posedge clk); @(negedge clk);
    nb_we_i = 0; m_val[1] = 32'h1234_5678;
    #1 chk(dp_rdata, 32'h1234_5678, "R4 new value");
    @(negedge clk); dp_req = 0;

    // R10 collision: local write wins
    dp_req = 1; dp_we = 1; dp_id = 8'd22; dp_wdata = 32'hAAAA_0001;
    nb_we_i = 1; nb_id_i = 8'd22; nb_wdata_i = 32'hBBBB_0002;
    @(posedge clk); @(negedge clk);
    nb_we_i = 0; dp_req = 0; m_val[2] = 32'hAAAA_0001;
    access(0, 22, 0, "R10 local wins");

    // R9 neighbour write to unbound ID ignored
    nb_we_i = 1; nb_id_i = 8'd200; nb_wdata_i = 32'hDEAD_BEEF;
    @(posedge clk); @(negedge clk);
    nb_we_i = 0;
    for (int i = 0; i < N_ENT; i++) access(0, m_id[i], 0, "R9 unchanged");

    // R7 removal sends ID to bus
    cfg(4, 0, 28);
    access(0, 28, 0, "R7 removed");

    // R8 deferred config during a bus access (ID 90 acks at once)
    inj = 1; inj_idx = 4; inj_id = 90;
    access(0, 90, 0, "R8 busy");
    inj = 0;
    access(0, 90, 0, "R8 old table");  // starts in first idle cycle: still a miss
    m_vld[4] = 1; m_id[4] = 90; m_val[4] = 0;
    access(0, 90, 0, "R8 applied");
    // R8 with a waiting access (ID 94 waits one cycle)
    inj = 1; inj_idx = 5; inj_id = 94;
    access(0, 94, 0, "R8 busy wait");
    inj = 0;
    @(negedge clk);
    m_vld[5] = 1; m_id[5] = 94; m_val[5] = 0;
    access(0, 94, 0, "R8 applied wait");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule